// File: doc/BRIEF.md
# Custom-Operation Dispatch Unit

This unit connects a processor pipeline to a small set of resident custom operations. Each of four slots holds an opcode tag and a settle latency. When the pipeline issues a custom opcode, the unit compares it against every valid tag.

On a hit, the unit holds the pipeline stall until two things are true: all operand values taken live from the register file are marked valid, and the slot's settle time has elapsed. It then presents the slot's result on the writeback bus for one cycle and releases the stall.

On a miss, it raises a configuration request carrying the opcode and keeps the pipeline stalled. When the loader signals completion, the opcode is installed into the next slot in round-robin order and the operation proceeds as a hit.

Each slot's logic is stateless: a combinational function of the operands, chosen by the two low bits of its tag.

The issuing side holds `op_issue`, `op_code` and `rf_data` steady while `stall` is high. It drops or changes them only in the cycle after `wb_valid`.

Top module: `rfu_dispatch`

## Requirements
- R1: After reset, `stall`, `wb_valid` and `cfg_req` are low and no slot is resident, so the first issued opcode misses.
- R2: An opcode that matches a resident tag stalls from its issue cycle on. `wb_valid` pulses for exactly one cycle, and in that cycle `stall` is low. The state machine returns to idle on the following clock.
- R3: `wb_valid` is never raised while any of the four `rf_valid` bits is low. If an operand becomes valid late, the stall is extended.
- R4: Let `rf_valid` be all ones continuously from cycle V, and let the slot's latency be L. If the slot was already selected in cycle V, `wb_valid` rises in cycle V+L. If `rf_valid` drops, the count restarts. For a hit issued in cycle 0, this places `wb_valid` at max(1,V)+L.
- R5: For a miss issued in cycle 0:
  - `cfg_req` is high with `cfg_op` equal to the opcode from cycle 1 until the cycle in which `cfg_done` is sampled high.
  - `stall` stays high throughout.
  - If `cfg_done` is sampled in cycle M, `wb_valid` arrives at max(M+1,V)+L, where L is the value of `cfg_lat` in cycle M.
- R6: Installation fills slots 0,1,2,3,0,… round-robin, evicting the previous occupant, so an evicted opcode misses on its next issue.
- R7: Results are selected by tag bits [1:0]:
  - 0: the 32-bit sum of the four operands.
  - 1: the bitwise XOR of the four operands.
  - 2: the bitwise AND of the four operands.
  - 3: operand 0 bit-reversed, XOR operand 3.
  - Operand k occupies `rf_data[32k+31:32k]`.
- R8: While `op_issue` is low, `stall` and `wb_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_issue | input | 1 | A custom opcode is being issued |
| op_code | input | 6 | Issued custom opcode |
| rf_data | input | 128 | Live operand values, four 32-bit words |
| rf_valid | input | 4 | Per-operand valid bits from the register file |
| cfg_done | input | 1 | Loader finished installing the requested opcode |
| cfg_lat | input | 4 | Settle latency for the slot being installed |
| cfg_req | output | 1 | Configuration load requested |
| cfg_op | output | 6 | Opcode to load |
| stall | output | 1 | Hold the pipeline |
| wb_valid | output | 1 | Writeback result valid this cycle |
| wb_data | output | 32 | Writeback result |

## Verification
The assertions take the following for granted:
- The issuing side holds `op_issue` and `op_code` steady while `stall` is high.
- `cfg_done` comes only while a request is pending.

Under those two conditions a pending request implies a stall, and tags stay unique. The stimulus respects both rules. Each operation keeps its inputs fixed from issue until the writeback cycle, and the bench drops `op_issue` for one cycle afterwards. `cfg_done` is pulsed once, only on operations the bench model predicts to miss. The random operand-valid patterns before the valid point are drawn so that they never have all four bits set.

// File: rtl/rfu_dispatch.sv
module rfu_dispatch #(
  parameter int NSLOT = 4,
  parameter int NOPND = 4,
  parameter int W     = 32,
  parameter int OPW   = 6,
  parameter int LATW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_issue,
  input  logic [OPW-1:0]     op_code,
  input  logic [NOPND*W-1:0] rf_data,
  input  logic [NOPND-1:0]   rf_valid,
  input  logic               cfg_done,
  input  logic [LATW-1:0]    cfg_lat,
  output logic               cfg_req,
  output logic [OPW-1:0]     cfg_op,
  output logic               stall,
  output logic               wb_valid,
  output logic [W-1:0]       wb_data
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_MISS} st_t;
  st_t st;

  logic [OPW-1:0]  tag  [NSLOT];
  logic [LATW-1:0] lat  [NSLOT];
  logic [NSLOT-1:0] tvld, hit;
  logic [SW-1:0]   rr, sel, hit_idx;
  logic [LATW-1:0] cnt;
  logic [W-1:0]    res [NSLOT];
  logic            all_v;

  assign all_v = &rf_valid;

  function automatic logic [W-1:0] slot_fn(input logic [1:0] f, input logic [NOPND*W-1:0] d);
    logic [W-1:0] acc, a0, rev;
    a0  = d[W-1:0];
    acc = (f == 2'd2) ? '1 : '0;
    for (int k = 0; k < NOPND; k++) begin
      case (f)
        2'd0: acc = acc + d[k*W +: W];
        2'd1: acc = acc ^ d[k*W +: W];
        default: acc = acc & d[k*W +: W];
      endcase
    end
    for (int b = 0; b < W; b++) rev[b] = a0[W-1-b];
    if (f == 2'd3) acc = rev ^ d[(NOPND-1)*W +: W];
    return acc;
  endfunction

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign hit[i] = tvld[i] && (tag[i] == op_code);
    assign res[i] = slot_fn(tag[i][1:0], rf_data);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NSLOT; i++)
      if (hit[i]) hit_idx = SW'(i);
  end

  assign wb_valid = (st == S_BUSY) && all_v && (cnt == '0);
  assign wb_data  = wb_valid ? res[sel] : '0;
  assign stall    = op_issue && !wb_valid;
  assign cfg_req  = (st == S_MISS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tvld   <= '0;
      rr     <= '0;
      sel    <= '0;
      cnt    <= '0;
      cfg_op <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        tag[i] <= '0;
        lat[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (op_issue) begin
          if (|hit) begin
            st  <= S_BUSY;
            sel <= hit_idx;
            cnt <= lat[hit_idx];
          end else begin
            st     <= S_MISS;
            cfg_op <= op_code;
          end
        end
        S_MISS: if (cfg_done) begin
          tag[rr]  <= cfg_op;
          lat[rr]  <= cfg_lat;
          tvld[rr] <= 1'b1;
          sel      <= rr;
          cnt      <= cfg_lat;
          rr       <= (rr == SW'(NSLOT-1)) ? '0 : rr + 1'b1;
          st       <= S_BUSY;
        end
        S_BUSY: begin
          if (wb_valid)   st  <= S_IDLE;
          else if (!all_v) cnt <= lat[sel];
          else            cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_tag_unique_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  p_wb_single_r2:  assert property (@(posedge clk) disable iff (!rst_n) wb_valid |=> !wb_valid);
  p_wb_opnds_r3:   assert property (@(posedge clk) disable iff (!rst_n) wb_valid |-> all_v);
  p_settle_r4:     assert property (@(posedge clk) disable iff (!rst_n)
                     (wb_valid && lat[sel] != '0) |-> $past(all_v));
  p_req_hold_r5:   assert property (@(posedge clk) disable iff (!rst_n)
                     (cfg_req && !cfg_done) |=> (cfg_req && $stable(cfg_op)));
  p_req_stall_r5:  assert property (@(posedge clk) disable iff (!rst_n) cfg_req |-> stall);
  p_rr_step_r6:    assert property (@(posedge clk) disable iff (!rst_n)
                     (cfg_req && cfg_done) |=> (rr != $past(rr)));
endmodule

// File: tb/tb_rfu_dispatch.sv
module tb_rfu_dispatch;
  logic clk = 0, rst_n = 0;
  logic op_issue = 0, cfg_done = 0;
  logic [5:0] op_code = 0;
  logic [127:0] rf_data = 0;
  logic [3:0] rf_valid = 0, cfg_lat = 0;
  logic cfg_req, stall, wb_valid;
  logic [5:0] cfg_op;
  logic [31:0] wb_data;
  int n_chk = 0, n_fail = 0;

  logic [5:0] m_tag [4];
  logic [3:0] m_lat [4];
  logic [3:0] m_v;
  int m_rr;

  always #2 clk = ~clk;

  rfu_dispatch dut (.clk, .rst_n, .op_issue, .op_code, .rf_data, .rf_valid,
                    .cfg_done, .cfg_lat, .cfg_req, .cfg_op, .stall, .wb_valid, .wb_data);

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fn(input logic [1:0] f, input logic [127:0] d);
    logic [31:0] a = d[31:0], b = d[63:32], c = d[95:64], e = d[127:96], r;
    case (f)
      2'd0: ref_fn = a + b + c + e;
      2'd1: ref_fn = a ^ b ^ c ^ e;
      2'd2: ref_fn = a & b & c & e;
      default: begin
        for (int i = 0; i < 32; i++) r[31-i] = a[i];
        ref_fn = r ^ e;
      end
    endcase
  endfunction

  function automatic int find(input logic [5:0] op);
    find = -1;
    for (int i = 0; i < 4; i++) if (m_v[i] && m_tag[i] == op) find = i;
  endfunction

  function automatic int imax(input int a, input int b);
    return a > b ? a : b;
  endfunction

  // runs one op: d = first all-valid cycle, m = cfg_done cycle, lat = cfg_lat value
  task automatic run_op(input logic [5:0] op, input int d, input int m,
                        input logic [3:0] lat, input bit exp_miss);
    int slot = find(op);
    bit miss = (slot < 0);
    int exp_cyc, got = -1, L;
    bit req_ok = 1, stall_ok = 1;
    logic [31:0] got_d = 0;
    logic [127:0] data = {$urandom, $urandom, $urandom, $urandom};
    chk(miss == exp_miss, "R6 predicted hit/miss", miss, exp_miss);
    if (miss) begin
      L = lat; m_tag[m_rr] = op; m_lat[m_rr] = lat; m_v[m_rr] = 1; m_rr = (m_rr + 1) % 4;
      exp_cyc = imax(m + 1, d) + L;
    end else begin
      L = m_lat[slot]; exp_cyc = imax(1, d) + L;
    end
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      op_issue = 1; op_code = op; rf_data = data; cfg_lat = lat;
      rf_valid = (c >= d) ? 4'hF : 4'($urandom_range(0, 14));
      cfg_done = miss && (c == m);
      #1;
      if (miss) begin
        if (c == 0 && cfg_req) req_ok = 0;
        if (c >= 1 && c <= m && !(cfg_req && cfg_op == op)) req_ok = 0;
        if (c > m && cfg_req) req_ok = 0;
      end else if (cfg_req) req_ok = 0;
      if (wb_valid) begin got = c; got_d = wb_data; if (stall) stall_ok = 0; break; end
      if (!stall) stall_ok = 0;
    end
    @(negedge clk);
    op_issue = 0; cfg_done = 0; rf_valid = 0;
    #1;
    chk(got == exp_cyc, "R4 writeback cycle", got, exp_cyc);
    chk(got_d == ref_fn(op[1:0], data), "R7 result", got_d, ref_fn(op[1:0], data));
    chk(stall_ok, "R2 stall until writeback", stall_ok, 1);
    chk(!wb_valid && !stall, "R2 single pulse then idle", wb_valid, 0);
    if (miss) chk(req_ok, "R5 cfg_req window", req_ok, 1);
    else chk(req_ok, "R2 no cfg_req on hit", req_ok, 1);
  endtask

  initial begin
    int unsigned seed = $urandom(32'd636);
    logic [5:0] pool [6] = '{6'd8, 6'd13, 6'd22, 6'd31, 6'd40, 6'd53};
    m_v = 0; m_rr = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!stall && !wb_valid && !cfg_req, "R1 reset outputs", {stall, wb_valid, cfg_req}, 0);
    rst_n = 1;
    run_op(6'd10, 0, 1, 4'd0, 1);           // R1 first op misses
    run_op(6'd10, 0, 0, 4'd0, 0);           // R2 hit, zero latency
    run_op(6'd10, 5, 0, 4'd0, 0);           // R3 late operand
    run_op(6'd11, 0, 3, 4'd2, 1);           // R5 slow load
    run_op(6'd11, 3, 0, 4'd0, 0);           // R4 latency after late operand
    run_op(6'd12, 0, 1, 4'd3, 1);
    run_op(6'd13, 2, 2, 4'd1, 1);
    run_op(6'd14, 0, 1, 4'd1, 1);           // R6 evicts slot 0 (op 10)
    run_op(6'd10, 0, 1, 4'd0, 1);           // R6 evicted op misses, evicts 11
    run_op(6'd12, 0, 0, 4'd0, 0);           // R6 survivor hits
    run_op(6'd11, 0, 1, 4'd2, 1);           // R6 evicted op misses
    for (int i = 0; i < 8; i++) begin       // R8 idle
      @(negedge clk); op_issue = 0; rf_valid = 4'($urandom); #1;
      chk(!stall && !wb_valid, "R8 idle quiet", {stall, wb_valid}, 0);
    end
    for (int i = 0; i < 150; i++) begin
      logic [5:0] op = pool[$urandom_range(0, 5)];
      run_op(op, $urandom_range(0, 4), $urandom_range(1, 3),
             4'($urandom_range(0, 3)), find(op) < 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule